// File: doc/BRIEF.md
# Pipelined ADC Sampling Controller

This block paces an external pipelined sampling converter and gathers its results. It produces a periodic convert-start pulse whose period and high time are given in system-clock cycles. It watches the converter's end-of-conversion line and latches the parallel output word each time that line falls. Because the converter returns the result of a conversion three pulses after that conversion's own start pulse, the block drops the first three captures of every run. It tags each later word with the index of the sample the word belongs to.

Before any pulse is issued, the timing settings are checked against the converter's limits, converted to nanoseconds with the clock-period parameter:

- The period must be at least 500 ns, which is the 2 MHz ceiling on the sample rate.
- The low time must be at least 40 ns.
- The high time must be at least 40 ns.
- At 1 MHz and faster, the high time must also fall in one of two windows: 40 to 175 ns, or 280 to 460 ns.

An illegal setting raises an error flag and keeps the start line quiet. The recommended operating point is a period of 125 cycles with a 13-cycle high time, which is 1 MHz with a 104 ns pulse at an 8 ns clock.

Results leave on a stream that carries a one-cycle valid strobe, the data word and the index. There is no ready input and no back-pressure. The converter cannot be stalled, so the consumer must take each word in the cycle it is offered, and words arrive at most once per sample period. Control and status pins are plain levels.

Top module: `adc_pipe_ctrl`

## Requirements
- R1: While running, `conv_start` is high for exactly `cfg_high` cycles and rises every `cfg_period` cycles.
- R2: When the period is 1000 ns or less, the high time is legal only if it lies in [40,175] ns or in [280,460] ns (both bounds inclusive).
- R3: When the period is above 1000 ns, any high time of at least 40 ns is legal. In every case the period must be at least 500 ns, the high time at least 40 ns, and the low time (`cfg_period - cfg_high`) at least 40 ns.
- R4: `cfg_err` is 1 in the cycle after the settings became illegal. While `cfg_err` is 1, `conv_start` stays low, even with `en` high.
- R5: In each run, the first three falls of `eoc` produce no `out_valid`. Every later fall produces one, so a run of N complete conversions yields N-3 strobes (none when N is 3).
- R6: With each strobe, `out_data` equals the word on `adc_data` at the `eoc` fall. `out_index` counts 0, 1, 2, and so on within a run, and equals the index of the start pulse that sampled the word.
- R7: `out_valid` is high for a single cycle per capture and is never high in two consecutive cycles.
- R8: Dropping `en`, or asserting reset, ends the run. The next run again drops three captures and restarts `out_index` at 0.
- R9: During reset, `conv_start`, `out_valid` and `cfg_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable |
| cfg_period | input | CW | Sample period in clock cycles |
| cfg_high | input | CW | Start-pulse high time in clock cycles |
| eoc | input | 1 | End-of-conversion line from the converter (asynchronous) |
| adc_data | input | DW | Converter parallel output word |
| conv_start | output | 1 | Convert-start pulse to the converter |
| out_valid | output | 1 | One-cycle strobe for a captured, aligned word |
| out_data | output | DW | Captured word |
| out_index | output | IW | Sample index of the captured word |
| cfg_err | output | 1 | Illegal timing settings |

## Verification
The settings are swept across each edge of the two fast-mode windows, the low-time floor and the 500 ns period floor. Each pair is placed one cycle inside and one cycle outside its boundary, so an off-by-one in any limit changes the error flag. Randomly drawn periods from both sides of 1 µs, with high times from either window, confirm that pulse width and period track the settings rather than a fixed value. A converter model returns each sample three pulses late. Comparing data and index per strobe therefore distinguishes a latency of three from two or four, and runs of exactly three pulses, plus runs ended by reset or by disable, show that the fill state restarts.

// File: rtl/adc_pipe_pkg.sv
package adc_pipe_pkg;

  localparam int unsigned NS_HIGH_FLOOR  = 40;
  localparam int unsigned NS_WIN_A_TOP   = 175;
  localparam int unsigned NS_WIN_B_LOW   = 280;
  localparam int unsigned NS_WIN_B_TOP   = 460;
  localparam int unsigned NS_LOW_FLOOR   = 40;
  localparam int unsigned NS_PERIOD_MIN  = 500;
  localparam int unsigned NS_FAST_BORDER = 1000;

  function automatic logic timing_legal(input int unsigned per_c,
                                        input int unsigned hi_c,
                                        input int unsigned clk_ns);
    int unsigned per_ns;
    int unsigned hi_ns;
    int unsigned lo_ns;
    logic ok;
    per_ns = per_c * clk_ns;
    hi_ns  = hi_c * clk_ns;
    lo_ns  = (hi_c < per_c) ? (per_c - hi_c) * clk_ns : 0;
    ok = (hi_c < per_c) && (per_ns >= NS_PERIOD_MIN) &&
         (hi_ns >= NS_HIGH_FLOOR) && (lo_ns >= NS_LOW_FLOOR);
    if (per_ns <= NS_FAST_BORDER)
      ok = ok && ((hi_ns <= NS_WIN_A_TOP) ||
                  ((hi_ns >= NS_WIN_B_LOW) && (hi_ns <= NS_WIN_B_TOP)));
    return ok;
  endfunction

endpackage

// File: rtl/adc_cfg_check.sv
module adc_cfg_check
  import adc_pipe_pkg::*;
#(
  parameter int CW = 16,
  parameter int unsigned CLK_NS = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] period,
  input  logic [CW-1:0] high,
  output logic          err
);

  always_ff @(posedge clk) begin
    if (!rst_n) err <= 1'b0;
    else        err <= !timing_legal(32'(period), 32'(high), CLK_NS);
  end

  logic armed;
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R3: an accepted setting always leaves a nonzero low time
  a_r3_low_time: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !err && $stable(period) && $stable(high)) |-> (high < period));

endmodule

// File: rtl/adc_start_gen.sv
module adc_start_gen #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] period,
  input  logic [CW-1:0] high,
  output logic          start
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt   <= '0;
      start <= 1'b0;
    end else begin
      start <= (cnt < high);
      cnt   <= (cnt >= period - CW'(1)) ? '0 : cnt + CW'(1);
    end
  end

  logic [CW-1:0] hi_run;
  always_ff @(posedge clk) begin
    if (!rst_n) hi_run <= '0;
    else        hi_run <= start ? hi_run + CW'(1) : '0;
  end

  // R4: idle generator keeps the line low
  a_r4_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !start);

  // R1: a pulse never outlasts the programmed high time
  a_r1_width_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (start && $past(run)) |-> (hi_run < $past(high)));

endmodule

// File: rtl/adc_capture.sv
module adc_capture #(
  parameter int DW  = 12,
  parameter int IW  = 16,
  parameter int LAT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          eoc,
  input  logic [DW-1:0] adc_data,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic [IW-1:0] out_index
);

  localparam int FW = $clog2(LAT + 2);
  localparam logic [FW-1:0] FULL = FW'(LAT);

  logic s1, s2, s3;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= eoc;
      s2 <= s1;
      s3 <= s2;
    end
  end

  logic fall;
  assign fall = s3 & ~s2;

  logic [FW-1:0] fill;
  logic [IW-1:0] idx_nxt;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      fill    <= '0;
      idx_nxt <= '0;
    end else if (fall) begin
      if (fill != FULL) fill <= fill + FW'(1);
      else              idx_nxt <= idx_nxt + IW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_index <= '0;
    end else begin
      out_valid <= run && fall && (fill == FULL);
      if (run && fall && (fill == FULL)) begin
        out_data  <= adc_data;
        out_index <= idx_nxt;
      end
    end
  end

  logic          seen;
  logic [IW-1:0] last_idx;
  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      seen     <= 1'b0;
      last_idx <= '0;
    end else if (out_valid) begin
      seen     <= 1'b1;
      last_idx <= out_index;
    end
  end

  // R7: the strobe lasts one cycle
  a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R8: leaving the run silences the output stream
  a_r8_quiet_stop: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !out_valid);

  // R6: indices inside a run advance by one
  a_r6_index_step: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && seen) |-> (out_index == last_idx + IW'(1)));

  // R6: the first strobe of a run carries index 0
  a_r6_first_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !seen) |-> (out_index == '0));

endmodule

// File: rtl/adc_pipe_ctrl.sv
module adc_pipe_ctrl #(
  parameter int DW  = 12,
  parameter int IW  = 16,
  parameter int CW  = 16,
  parameter int LAT = 3,
  parameter int unsigned CLK_NS = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] cfg_period,
  input  logic [CW-1:0] cfg_high,
  input  logic          eoc,
  input  logic [DW-1:0] adc_data,
  output logic          conv_start,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic [IW-1:0] out_index,
  output logic          cfg_err
);

  logic run;

  adc_cfg_check #(.CW(CW), .CLK_NS(CLK_NS)) u_check (
    .clk    (clk),
    .rst_n  (rst_n),
    .period (cfg_period),
    .high   (cfg_high),
    .err    (cfg_err)
  );

  assign run = en & ~cfg_err;

  adc_start_gen #(.CW(CW)) u_gen (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .period (cfg_period),
    .high   (cfg_high),
    .start  (conv_start)
  );

  adc_capture #(.DW(DW), .IW(IW), .LAT(LAT)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .eoc       (eoc),
    .adc_data  (adc_data),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_index (out_index)
  );

  // R4: an error flag blocks the next start cycle
  a_r4_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> !conv_start);

  // R9: outputs are cleared by reset
  a_r9_reset_clear: assert property (@(posedge clk)
    $past(!rst_n) |-> (!conv_start && !out_valid && !cfg_err));

endmodule

// File: tb/adc_pipe_ctrl_bench.sv
`timescale 1ns/1ps
module adc_pipe_ctrl_bench;

  localparam int DW = 12;
  localparam int IW = 16;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic [CW-1:0] cfg_period = 16'd125;
  logic [CW-1:0] cfg_high = 16'd13;
  logic          eoc = 1'b0;
  logic [DW-1:0] adc_data = '0;
  logic          conv_start;
  logic          out_valid;
  logic [DW-1:0] out_data;
  logic [IW-1:0] out_index;
  logic          cfg_err;

  always #4 clk = ~clk;

  adc_pipe_ctrl #(.DW(DW), .IW(IW), .CW(CW), .LAT(3), .CLK_NS(8)) u_adc_pipe_ctrl (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg_period(cfg_period), .cfg_high(cfg_high),
    .eoc(eoc), .adc_data(adc_data), .conv_start(conv_start), .out_valid(out_valid),
    .out_data(out_data), .out_index(out_index), .cfg_err(cfg_err)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit exp_legal(input int p, input int h);
    int lo;
    lo = p - h;
    if (h <= 0 || lo * 8 < 40) return 1'b0;
    if (p * 8 < 500) return 1'b0;
    if (h * 8 < 40) return 1'b0;
    if (p * 8 > 1000) return 1'b1;
    if (h * 8 <= 175) return 1'b1;
    return (h * 8 >= 280) && (h * 8 <= 460);
  endfunction

  // converter model: each word appears three pulses after its sample
  logic [DW-1:0] samp [0:63];
  int mcount = 0;
  int mk;
  always @(posedge conv_start) begin
    mk = mcount;
    mcount++;
    samp[mk % 64] = DW'($urandom);
    #8 eoc = 1'b1;
    #260;
    adc_data = (mk >= 3) ? samp[(mk - 3) % 64] : DW'($urandom);
    eoc = 1'b0;
  end

  // output monitor
  int  exp_idx = 0;
  int  nvalid = 0;
  bit  prev_valid = 1'b0;
  always @(negedge clk) begin
    if (out_valid) begin
      nvalid++;
      chk(out_data == samp[exp_idx % 64], "R6 data", int'(out_data), int'(samp[exp_idx % 64]));
      chk(int'(out_index) == exp_idx, "R6 index", int'(out_index), exp_idx);
      exp_idx++;
      if (prev_valid) chk(1'b0, "R7 strobe width", 2, 1);
    end
    prev_valid = out_valid;
  end

  // pulse monitor
  bit have_rise = 1'b0;
  bit prev_start = 1'b0;
  int since = 0;
  int hi_len = 0;
  always @(negedge clk) begin
    if (conv_start) hi_len++;
    if (conv_start && !prev_start) begin
      if (have_rise) chk(since == int'(cfg_period), "R1 period", since, int'(cfg_period));
      have_rise = 1'b1;
      since = 0;
    end
    if (!conv_start && prev_start) chk(hi_len == int'(cfg_high), "R1 width", hi_len, int'(cfg_high));
    if (!conv_start) hi_len = 0;
    since++;
    prev_start = conv_start;
  end

  task automatic fresh_run();
    mcount = 0;
    exp_idx = 0;
    nvalid = 0;
    have_rise = 1'b0;
  endtask

  task automatic wait_last_capture(input int n);
    while (mcount < n) @(negedge clk);
    @(negedge eoc);
    repeat (6) @(negedge clk);
    while (conv_start) @(negedge clk);
  endtask

  // R2 R3 R4 R5 R1: one configuration, one run
  task automatic run_cfg(input int p, input int h, input int n);
    bit legal;
    int pulses;
    legal = exp_legal(p, h);
    @(negedge clk);
    en = 1'b0;
    cfg_period = CW'(p);
    cfg_high = CW'(h);
    repeat (2) @(negedge clk);
    chk(cfg_err == !legal, (p * 8 > 1000) ? "R3 legality" : "R2 legality", int'(cfg_err), int'(!legal));
    if (legal) begin
      fresh_run();
      en = 1'b1;
      wait_last_capture(n);
      en = 1'b0;
      repeat (8) @(negedge clk);
      chk(nvalid == n - 3, "R5 strobe count", nvalid, n - 3);
    end else begin
      pulses = 0;
      en = 1'b1;
      for (int i = 0; i < 300; i++) begin
        @(negedge clk);
        if (conv_start) pulses++;
      end
      chk(pulses == 0, "R4 start quiet on error", pulses, 0);
      en = 1'b0;
    end
    repeat (20) @(negedge clk);
  endtask

  initial begin
    #(8 * 190000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(conv_start == 1'b0, "R9 reset start", int'(conv_start), 0);
    chk(out_valid == 1'b0, "R9 reset valid", int'(out_valid), 0);
    chk(cfg_err == 1'b0, "R9 reset err", int'(cfg_err), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // directed corners
    run_cfg(125, 13, 6);
    run_cfg(125, 13, 3);   // R5 exactly three pulses, no strobe
    run_cfg(125, 5, 5);
    run_cfg(125, 4, 5);
    run_cfg(125, 21, 5);
    run_cfg(125, 22, 5);
    run_cfg(125, 34, 5);
    run_cfg(125, 35, 5);
    run_cfg(125, 57, 5);
    run_cfg(125, 58, 5);
    run_cfg(62, 13, 5);
    run_cfg(63, 13, 5);
    run_cfg(63, 57, 5);
    run_cfg(63, 58, 5);
    run_cfg(126, 80, 5);
    run_cfg(125, 80, 5);
    run_cfg(200, 195, 5);
    run_cfg(200, 196, 5);

    // R8: reset ends a run, the next run refills from index 0
    @(negedge clk);
    cfg_period = 16'd125;
    cfg_high = 16'd13;
    fresh_run();
    en = 1'b1;
    wait_last_capture(6);
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(nvalid == 3, "R8 first run count", nvalid, 3);
    fresh_run();
    rst_n = 1'b1;
    wait_last_capture(7);
    en = 1'b0;
    repeat (8) @(negedge clk);
    chk(nvalid == 4, "R8 refill after reset", nvalid, 4);
    repeat (20) @(negedge clk);

    // random settings from both rate regions
    for (int r = 0; r < 14; r++) begin
      int p;
      int h;
      p = 60 + int'($urandom_range(0, 160));
      case ($urandom_range(0, 3))
        0: h = 5 + int'($urandom_range(0, 16));
        1: h = 35 + int'($urandom_range(0, 22));
        2: h = 5 + int'($urandom_range(0, 200));
        default: h = 1 + int'($urandom_range(0, 10));
      endcase
      run_cfg(p, h, 4 + int'($urandom_range(0, 5)));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule